// File: doc/BRIEF.md
# Compact 16-bit Single-Cycle Processor Core

This core runs one 16-bit instruction per clock. It uses a small load/store instruction set with a 4-bit opcode and four instruction layouts. It keeps eight 16-bit general registers. Each cycle the core presents the program counter on the instruction port and takes the instruction word back in the same cycle. It decodes the word, reads up to two registers and computes a result. At the next rising edge it writes the destination register and moves the program counter. Load and store use a separate data port with a combinational read path. A store raises the write enable for exactly the cycle of that instruction.

A full 16-bit constant is built in two steps. The first step sets the nine low bits and clears the upper bits. The second step fills the seven upper bits and keeps the low nine. Conditional branches are relative to the following instruction. Jumps are absolute within the first 8 KiB of the address space. Opcodes 1101 to 1111 do nothing except advance the program counter.

Top module: `cpu16_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter returns to 0. In the first cycle after `rst` is released, `imem_addr` is 0 and `dmem_we` is low.
- R2: Every instruction other than a taken branch or a jump advances the program counter by 2. Opcodes 1101, 1110 and 1111 change no register and no memory. The program counter is always even.
- R3: Opcode 0000 is a register operation. Its fields are a=[11:9], b=[8:6], dest=[5:3] and op=[2:0]. It writes dest with a+b (op 000), a-b (001), a AND b (010), a OR b (011), NOR (100), XOR (101) or a signed a<b giving 1 or 0 (110). Op 111 writes nothing.
- R4: Opcode 0001 writes register [8:6] with register [11:9] plus the sign-extended 6-bit field [5:0].
- R5: Opcodes 0100 and 0101 write register [8:6] with register [11:9] shifted left or right (logical). The shift amount is the unsigned value of bits [3:0]; bits [5:4] are ignored.
- R6: Opcode 0110 loads register [8:6] from data address reg[11:9]+sext([5:0]). Opcode 0111 stores register [8:6] to that address. `dmem_we` is high only during a store.
- R7: Opcode 1000 branches when registers [11:9] and [8:6] are equal, and opcode 1001 branches when they differ. The branch target is PC+2+(sext([5:0])<<1).
- R8: Opcode 1010 sets the program counter to {3'b000, [11:0], 1'b0}.
- R9: Opcode 1011 writes register [11:9] with {7'b0, [8:0]}. Opcode 1100 replaces bits [15:9] of register [11:9] with bits [6:0] of the instruction and keeps its bits [8:0].
- R10: Register 0 reads as zero, and writes to it are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 16 | Byte address of the current instruction (registered PC) |
| imem_data | input | 16 | Instruction word at `imem_addr`, valid in the same cycle |
| dmem_addr | output | 16 | Data byte address for load or store |
| dmem_wdata | output | 16 | Store data |
| dmem_we | output | 1 | Store strobe, written at the rising edge |
| dmem_rdata | input | 16 | Load data at `dmem_addr`, valid in the same cycle |

## Verification
The embedded properties check the control flow every cycle. The program counter stays even. It steps by exactly 2 after any instruction that is not a branch or a jump. A jump lands on the shifted absolute field. The store strobe rises only under a store opcode. A set-less-than result never exceeds one. Arithmetic results, the two-step constant build, shift-amount truncation, discarded writes to register 0, the inert function code 111 and the branch decisions only become visible through the bench's program. For these the bench compares instruction addresses and store traffic against its behavioural model on every cycle, then checks the final memory image.

// File: rtl/cpu16_pkg.sv
package cpu16_pkg;
  localparam int XLEN  = 16;
  localparam int NREG  = 8;
  localparam int RAW   = $clog2(NREG);
  localparam int SHW   = $clog2(XLEN);

  typedef enum logic [3:0] {
    OP_REG  = 4'b0000,
    OP_ADDI = 4'b0001,
    OP_SHL  = 4'b0100,
    OP_SHR  = 4'b0101,
    OP_LOAD = 4'b0110,
    OP_STOR = 4'b0111,
    OP_BEQ  = 4'b1000,
    OP_BNE  = 4'b1001,
    OP_JMP  = 4'b1010,
    OP_LOLO = 4'b1011,
    OP_LOHI = 4'b1100
  } opc_e;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_NOR,
    ALU_XOR, ALU_SLT, ALU_SHL, ALU_SHR
  } alu_e;

  typedef enum logic [1:0] {WB_ALU, WB_MEM, WB_LOW, WB_HIGH} wbsel_e;

  typedef struct packed {
    alu_e             alu_op;
    logic             b_is_imm;
    logic [XLEN-1:0]  imm;
    logic             wr_en;
    logic [RAW-1:0]   wr_idx;
    wbsel_e           wb_sel;
    logic             store;
    logic             br_eq;
    logic             br_ne;
    logic             jump;
  } ctrl_t;
endpackage

// File: rtl/cpu16_regfile.sv
module cpu16_regfile #(
  parameter int W  = 16,
  parameter int N  = 8,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ra,
  input  logic [AW-1:0] rb,
  output logic [W-1:0]  qa,
  output logic [W-1:0]  qb,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd
);
  logic [W-1:0] regs [N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) regs[i] <= '0;
    end else if (we && wa != '0) begin
      regs[wa] <= wd;
    end
  end

  assign qa = (ra == '0) ? '0 : regs[ra];
  assign qb = (rb == '0) ? '0 : regs[rb];
endmodule

// File: rtl/cpu16_alu.sv
module cpu16_alu
  import cpu16_pkg::*;
#(
  parameter int W = 16,
  localparam int SW = $clog2(W)
) (
  input  logic         clk,
  input  logic         rst,
  input  alu_e         op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  always_comb begin
    unique case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_NOR: y = ~(a | b);
      ALU_XOR: y = a ^ b;
      ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      ALU_SHL: y = a << b[SW-1:0];
      ALU_SHR: y = a >> b[SW-1:0];
      default: y = a + b;
    endcase
  end

  // R3
  slt_bool_chk: assert property (@(posedge clk) disable iff (rst)
    (op == ALU_SLT) |-> (y[W-1:1] == '0));
endmodule

// File: rtl/cpu16_decode.sv
module cpu16_decode
  import cpu16_pkg::*;
(
  input  logic [15:0] ins,
  output ctrl_t       c
);
  logic [3:0] opc;
  logic [2:0] fn;
  logic [XLEN-1:0] sext6, zext4;

  assign opc   = ins[15:12];
  assign fn    = ins[2:0];
  assign sext6 = {{(XLEN-6){ins[5]}}, ins[5:0]};
  assign zext4 = {{(XLEN-4){1'b0}}, ins[3:0]};

  always_comb begin
    c          = '0;
    c.alu_op   = ALU_ADD;
    c.wb_sel   = WB_ALU;
    c.imm      = sext6;
    c.wr_idx   = ins[8:6];
    case (opc)
      OP_REG: begin
        c.wr_idx = ins[5:3];
        c.wr_en  = (fn != 3'b111);
        case (fn)
          3'b000:  c.alu_op = ALU_ADD;
          3'b001:  c.alu_op = ALU_SUB;
          3'b010:  c.alu_op = ALU_AND;
          3'b011:  c.alu_op = ALU_OR;
          3'b100:  c.alu_op = ALU_NOR;
          3'b101:  c.alu_op = ALU_XOR;
          3'b110:  c.alu_op = ALU_SLT;
          default: c.alu_op = ALU_ADD;
        endcase
      end
      OP_ADDI: begin c.b_is_imm = 1'b1; c.wr_en = 1'b1; end
      OP_SHL:  begin c.b_is_imm = 1'b1; c.wr_en = 1'b1; c.imm = zext4; c.alu_op = ALU_SHL; end
      OP_SHR:  begin c.b_is_imm = 1'b1; c.wr_en = 1'b1; c.imm = zext4; c.alu_op = ALU_SHR; end
      OP_LOAD: begin c.b_is_imm = 1'b1; c.wr_en = 1'b1; c.wb_sel = WB_MEM; end
      OP_STOR: begin c.b_is_imm = 1'b1; c.store = 1'b1; end
      OP_BEQ:  c.br_eq = 1'b1;
      OP_BNE:  c.br_ne = 1'b1;
      OP_JMP:  c.jump  = 1'b1;
      OP_LOLO: begin c.wr_en = 1'b1; c.wr_idx = ins[11:9]; c.wb_sel = WB_LOW;  end
      OP_LOHI: begin c.wr_en = 1'b1; c.wr_idx = ins[11:9]; c.wb_sel = WB_HIGH; end
      default: ;
    endcase
  end
endmodule

// File: rtl/cpu16_core.sv
module cpu16_core
  import cpu16_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  output logic [AW-1:0] imem_addr,
  input  logic [15:0]   imem_data,
  output logic [AW-1:0] dmem_addr,
  output logic [15:0]   dmem_wdata,
  output logic          dmem_we,
  input  logic [15:0]   dmem_rdata
);
  localparam int LOWB = 9;
  localparam int JW   = 12;

  logic [AW-1:0]   pc, pc_next, pc_inc, br_tgt, jmp_tgt;
  ctrl_t           c;
  logic [XLEN-1:0] rs_val, rt_val, alu_b, alu_y, wb_val;
  logic            taken;

  cpu16_decode u_dec (.ins(imem_data), .c(c));

  cpu16_regfile #(.W(XLEN), .N(NREG)) u_rf (
    .clk(clk), .rst(rst),
    .ra(imem_data[11:9]), .rb(imem_data[8:6]),
    .qa(rs_val), .qb(rt_val),
    .we(c.wr_en), .wa(c.wr_idx), .wd(wb_val)
  );

  assign alu_b = c.b_is_imm ? c.imm : rt_val;

  cpu16_alu #(.W(XLEN)) u_alu (
    .clk(clk), .rst(rst), .op(c.alu_op), .a(rs_val), .b(alu_b), .y(alu_y)
  );

  always_comb begin
    case (c.wb_sel)
      WB_MEM:  wb_val = dmem_rdata;
      WB_LOW:  wb_val = {{(XLEN-LOWB){1'b0}}, imem_data[LOWB-1:0]};
      WB_HIGH: wb_val = {imem_data[XLEN-LOWB-1:0], rs_val[LOWB-1:0]};
      default: wb_val = alu_y;
    endcase
  end

  assign dmem_addr  = alu_y[AW-1:0];
  assign dmem_wdata = rt_val;
  assign dmem_we    = c.store;

  assign taken   = (c.br_eq && (rs_val == rt_val)) || (c.br_ne && (rs_val != rt_val));
  assign pc_inc  = pc + AW'(2);
  assign br_tgt  = pc_inc + {c.imm[AW-2:0], 1'b0};
  assign jmp_tgt = AW'({imem_data[JW-1:0], 1'b0});

  always_comb begin
    if (c.jump)      pc_next = jmp_tgt;
    else if (taken)  pc_next = br_tgt;
    else             pc_next = pc_inc;
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pc_next;
  end

  assign imem_addr = pc;

  // R2
  pc_even_chk: assert property (@(posedge clk) disable iff (rst) imem_addr[0] == 1'b0);

  // R2
  pc_seq_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !($past(imem_data[15:12]) inside {4'b1000, 4'b1001, 4'b1010}))
      |-> imem_addr == $past(imem_addr) + AW'(2));

  // R8
  jump_tgt_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(imem_data[15:12]) == 4'b1010)
      |-> imem_addr == AW'({$past(imem_data[11:0]), 1'b0}));

  // R6
  store_only_chk: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> imem_data[15:12] == 4'b0111);
endmodule

// File: tb/sim_cpu16_core.sv
`timescale 1ns/1ps
module sim_cpu16_core;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
  logic dmem_we;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cpu16_core u0 (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
    .dmem_rdata(dmem_rdata)
  );

  logic [15:0] im [64];
  logic [15:0] dm [128];
  assign imem_data  = im[imem_addr[6:1]];
  assign dmem_rdata = dm[dmem_addr[7:1]];
  always @(posedge clk) if (dmem_we) dm[dmem_addr[7:1]] <= dmem_wdata;

  // reference model state
  logic [15:0] mreg [8];
  logic [15:0] mmem [128];
  logic [15:0] mpc;

  function automatic logic [15:0] fR(int f, int a, int b, int d);
    return {4'b0000, 3'(a), 3'(b), 3'(d), 3'(f)};
  endfunction
  function automatic logic [15:0] fI(int op, int a, int b, int imm);
    return {4'(op), 3'(a), 3'(b), 6'(imm)};
  endfunction
  function automatic logic [15:0] fL(int op, int a, int imm);
    return {4'(op), 3'(a), 9'(imm)};
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic mwr(input int idx, input logic [15:0] v);
    if (idx != 0) mreg[idx] = v;
  endtask

  task automatic model_step(input logic [15:0] ins);
    logic [3:0] op; int s, t, d, f, simm;
    logic [15:0] a, b, ea, npc;
    op = ins[15:12]; s = ins[11:9]; t = ins[8:6]; d = ins[5:3]; f = ins[2:0];
    simm = ins[5] ? int'(ins[5:0]) - 64 : int'(ins[5:0]);
    a = mreg[s]; b = mreg[t];
    ea = a + 16'(simm);
    npc = mpc + 16'd2;
    case (op)
      4'd0: case (f)
        0: mwr(d, a + b);
        1: mwr(d, a - b);
        2: mwr(d, a & b);
        3: mwr(d, a | b);
        4: mwr(d, ~(a | b));
        5: mwr(d, a ^ b);
        6: mwr(d, ($signed(a) < $signed(b)) ? 16'd1 : 16'd0);
        default: ;
      endcase
      4'd1:  mwr(t, ea);
      4'd4:  mwr(t, a << ins[3:0]);
      4'd5:  mwr(t, a >> ins[3:0]);
      4'd6:  mwr(t, mmem[ea[7:1]]);
      4'd7:  mmem[ea[7:1]] = b;
      4'd8:  if (a == b) npc = mpc + 16'd2 + 16'(simm * 2);
      4'd9:  if (a != b) npc = mpc + 16'd2 + 16'(simm * 2);
      4'd10: npc = {3'b000, ins[11:0], 1'b0};
      4'd11: mwr(s, {7'b0, ins[8:0]});
      4'd12: mwr(s, {ins[6:0], mreg[s][8:0]});
      default: ;
    endcase
    mpc = npc;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) im[i] = 16'hD000;
    for (int i = 0; i < 128; i++) begin dm[i] = 16'hDEAD; mmem[i] = 16'hDEAD; end
    for (int i = 0; i < 8; i++) mreg[i] = 16'h0000;
    im[0]  = fL(11, 1, 9'h1FF);        // R9 low load
    im[1]  = fL(12, 1, 7'h55);         // R9 high load -> ABFF
    im[2]  = fL(11, 2, 5);
    im[3]  = fI(1, 0, 3, 6'h3D);       // R4 addi -3
    im[4]  = fR(0, 1, 2, 4);           // R3 add -> AC04
    im[5]  = fI(7, 0, 4, 0);           // mem[0]
    im[6]  = fR(1, 2, 3, 5);           // R3 sub -> 8
    im[7]  = fI(7, 0, 5, 2);
    im[8]  = fR(6, 3, 2, 6);           // R3 slt -> 1
    im[9]  = fI(7, 0, 6, 4);
    im[10] = fI(4, 2, 4, 6'h13);       // R5 shift 3 -> 0x28
    im[11] = fI(7, 0, 4, 6);
    im[12] = fI(5, 1, 5, 4);           // R5 srl -> 0ABF
    im[13] = fI(7, 0, 5, 8);
    im[14] = fI(1, 2, 0, 7);           // R10 write to r0
    im[15] = fI(7, 0, 0, 10);
    im[16] = 16'hD123;                 // R2 undefined opcode
    im[17] = fR(7, 1, 2, 6);           // R3 funct 111: no write
    im[18] = fI(7, 0, 6, 12);
    im[19] = fI(6, 0, 7, 2);           // R6 load -> 8
    im[20] = fI(1, 7, 7, 1);
    im[21] = fI(7, 0, 7, 14);
    im[22] = fL(11, 1, 3);
    im[23] = fI(1, 1, 1, 6'h3F);       // loop: r1--
    im[24] = fI(9, 1, 0, 6'h3E);       // R7 bne back
    im[25] = fI(8, 0, 0, 1);           // R7 beq skip
    im[26] = fI(7, 0, 1, 16);          // skipped
    im[27] = fI(8, 1, 2, 5);           // R7 beq not taken
    im[28] = fR(4, 2, 0, 4);           // nor -> FFFA
    im[29] = fR(5, 4, 2, 5);           // xor -> FFFF
    im[30] = fR(3, 2, 3, 6);           // or  -> FFFD
    im[31] = fI(7, 0, 5, 18);
    im[32] = fI(7, 0, 6, 20);
    im[33] = {4'b1010, 12'd33};        // R8 jump to self
    mpc = 16'h0000;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #0.5;
    chk("R1", "pc after reset", imem_addr, 0);
    chk("R1", "we after reset", dmem_we, 0);
    for (int cyc = 0; cyc < 70; cyc++) begin
      chk("R2", "pc", imem_addr, mpc);
      chk("R6", "we", dmem_we, (imem_data[15:12] == 4'd7) ? 1 : 0);
      if (imem_data[15:12] == 4'd7) begin
        chk("R6", "store addr", dmem_addr,
            mreg[imem_data[11:9]] + 16'({{10{imem_data[5]}}, imem_data[5:0]}));
        chk("R6", "store data", dmem_wdata, mreg[imem_data[8:6]]);
      end
      model_step(imem_data);
      @(posedge clk);
      @(negedge clk);
    end
    chk("R3", "add after two-step constant", dm[0], 16'hAC04);
    chk("R3", "sub", dm[1], 16'h0008);
    chk("R3", "slt signed", dm[2], 16'h0001);
    chk("R5", "shift amount low bits", dm[3], 16'h0028);
    chk("R5", "logical right shift", dm[4], 16'h0ABF);
    chk("R10", "r0 stays zero", dm[5], 16'h0000);
    chk("R3", "funct 111 inert", dm[6], 16'h0001);
    chk("R6", "load plus addi", dm[7], 16'h0009);
    chk("R7", "taken beq skipped store", dm[8], 16'hDEAD);
    chk("R3", "xor of nor", dm[9], 16'hFFFF);
    chk("R3", "or", dm[10], 16'hFFFD);
    chk("R8", "halt loop pc", imem_addr, 16'd66);
    chk("R9", "model high load", mreg[1], 16'h0000);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule